// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block gives a processor an atomic read-modify-write primitive built from a load-linked (LL) and a store-conditional (SC). An LL arms a single reservation: a valid flag together with the block address of the load. The reservation is cancelled by any event that shows another agent may have written the block, or that the local cache no longer holds it. Such events are a snooped invalidation or read-exclusive whose block address matches, a local eviction of the reserved block, or a context switch. A later SC reads the flag. It passes only if the reservation survived, and only a passing SC raises the write enable that lets the store go ahead.

A failing SC never raises the write enable, so it can never cause an invalidation or bus write. Each failure also opens an exponential backoff window. While the window is open the block withholds its bus-request permission, so processors that fetch the line exclusively at LL time do not livelock one another. The window doubles on each failure in a row, saturates at a parameterised maximum, and returns to its base length on the next success. Address comparison works on whole blocks. Offset bits below the block size are ignored.

Top module: `llsc_resv_unit`

## Requirements
- R1: With `ll_req` high at a rising edge, the reservation is armed with the block address of `ll_addr` (bits above log2(BLK_BYTES)). A later SC with no intervening cancelling event passes.
- R2: A snoop with `snp_valid` high cancels the reservation when its block address equals the reserved one and `snp_kind` is 2'b01 (invalidate) or 2'b10 (read-exclusive). Kinds 2'b00 (shared read) and 2'b11 have no effect, and neither does a snoop to any other block. Offset bits are never compared.
- R3: With `repl_valid` high and `repl_addr` in the reserved block, the reservation is cancelled. An eviction of any other block has no effect.
- R4: A `ctx_switch` pulse cancels the reservation whatever the address.
- R5: Every `sc_req` at a rising edge produces `sc_done` high for exactly the following cycle. `sc_pass` is high then only if the reservation was armed and was not cancelled in the SC's own cycle.
- R6: `sc_wr` is high only together with a passing `sc_pass`. A failing SC never asserts it.
- R7: A passing SC consumes the reservation, so a second SC with no new LL fails.
- R8: Within one cycle, a cancelling event that accompanies an SC makes that SC fail. An LL in the same cycle as a cancelling event still leaves the reservation armed. An LL in the same cycle as an SC leaves the SC judged on the old reservation and arms a new one.
- R9: With EXCL_BACKOFF=1, a failing SC drops `bus_ok` in the same cycle as its `sc_done`. It stays low for W cycles, where W is 1 for the first failure after reset or a success and doubles on each further failure, saturating at MAX_WIN.
- R10: A passing SC returns W to 1 and shows `bus_ok` high together with its `sc_done`.
- R11: After reset `sc_done`, `sc_pass` and `sc_wr` are low, `bus_ok` is high and no reservation is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_req | input | 1 | Load-linked issued this cycle |
| ll_addr | input | AW | Byte address of the load-linked |
| sc_req | input | 1 | Store-conditional issued this cycle |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_kind | input | 2 | Snoop kind: 00 read, 01 invalidate, 10 read-exclusive, 11 no effect |
| snp_addr | input | AW | Byte address of the snooped transaction |
| repl_valid | input | 1 | Local cache evicts a block this cycle |
| repl_addr | input | AW | Byte address inside the evicted block |
| ctx_switch | input | 1 | Context switch pulse |
| sc_done | output | 1 | SC result is valid this cycle |
| sc_pass | output | 1 | SC succeeded |
| sc_wr | output | 1 | Write enable for a successful SC |
| bus_ok | output | 1 | Permission to request the bus (low during backoff) |

## Verification
The SC decision and reservation cancellation can land in the same cycle. An SC issued alongside a matching invalidation, a matching eviction or a context switch must fail. An SC alongside a snoop to a neighbouring block must pass. The bench drives both inputs in one cycle and judges `sc_pass` and `sc_wr` on the following cycle. The LL paths are provoked the same way: LL together with a cancelling snoop, and LL together with an SC. Each is followed by a further SC that shows whether the reservation ended up armed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Snooped transaction kinds seen on the bus.
    typedef enum logic [1:0] {
        SNP_READ  = 2'b00,
        SNP_INVAL = 2'b01,
        SNP_RDX   = 2'b10,
        SNP_NONE  = 2'b11
    } snp_kind_e;

    // Registered result of a store-conditional.
    typedef struct packed {
        logic done;
        logic pass;
        logic wr;
    } sc_result_t;

    // Cancelling events of one cycle, gathered for the reservation register.
    typedef struct packed {
        logic snoop;
        logic evict;
        logic ctx;
    } kill_src_t;

    // Only kinds that take ownership of the block cancel a reservation.
    function automatic logic kind_takes_ownership(input logic [1:0] kind);
        return (kind == SNP_INVAL) || (kind == SNP_RDX);
    endfunction

    // Next backoff window: doubled, clamped at the ceiling.
    function automatic int unsigned next_window(input int unsigned cur,
                                                input int unsigned ceiling);
        int unsigned dbl;
        dbl = cur * 2;
        return (dbl > ceiling) ? ceiling : dbl;
    endfunction

endpackage

// File: rtl/llsc_blk_cmp.sv
module llsc_blk_cmp #(
    parameter int BW = 12
) (
    input  logic          en,
    input  logic [BW-1:0] blk_a,
    input  logic [BW-1:0] blk_b,
    output logic          hit
);
    always_comb hit = en && (blk_a == blk_b);
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
    parameter int BW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [BW-1:0] arm_blk,
    input  logic          drop,
    output logic          armed,
    output logic [BW-1:0] blk
);
    // LL outranks any same-cycle drop; a drop beats holding.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            blk   <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            blk   <= arm_blk;
        end else if (drop) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_backoff.sv
module llsc_backoff #(
    parameter int MAX_WIN = 8,
    parameter bit ENABLE  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_evt,
    input  logic pass_evt,
    output logic bus_ok
);
    localparam int WW = $clog2(MAX_WIN + 1);

    generate
        if (ENABLE) begin : g_on
            logic [WW-1:0] win;
            logic [WW-1:0] cnt;
            logic [WW-1:0] win_nxt;

            always_comb win_nxt = WW'(llsc_pkg::next_window(int'(win), MAX_WIN));

            always_ff @(posedge clk) begin
                if (rst) begin
                    win <= WW'(1);
                    cnt <= '0;
                end else if (pass_evt) begin
                    win <= WW'(1);
                    cnt <= '0;
                end else if (fail_evt) begin
                    cnt <= win;
                    win <= win_nxt;
                end else if (cnt != '0) begin
                    cnt <= cnt - WW'(1);
                end
            end

            always_comb bus_ok = (cnt == '0);
        end else begin : g_off
            logic unused_in;
            always_comb unused_in = clk ^ rst ^ fail_evt ^ pass_evt;
            always_comb bus_ok = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit #(
    parameter int AW           = 16,
    parameter int BLK_BYTES    = 16,
    parameter int MAX_WIN      = 8,
    parameter bit EXCL_BACKOFF = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ll_req,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_req,
    input  logic          snp_valid,
    input  logic [1:0]    snp_kind,
    input  logic [AW-1:0] snp_addr,
    input  logic          repl_valid,
    input  logic [AW-1:0] repl_addr,
    input  logic          ctx_switch,
    output logic          sc_done,
    output logic          sc_pass,
    output logic          sc_wr,
    output logic          bus_ok
);
    import llsc_pkg::*;

    localparam int OFF_W = $clog2(BLK_BYTES);
    localparam int BW    = AW - OFF_W;
    localparam int NCMP  = 2;   // 0: snoop port, 1: eviction port

    logic          armed;
    logic [BW-1:0] resv_blk;
    logic [NCMP-1:0]        cmp_en;
    logic [NCMP-1:0][BW-1:0] cmp_blk;
    logic [NCMP-1:0]        cmp_hit;
    kill_src_t     kill;
    logic          kill_any;
    logic          sc_ok;
    sc_result_t    res_q;

    // Offset bits never take part in a comparison.
    logic unused_offsets;
    always_comb unused_offsets = ^{ll_addr[OFF_W-1:0], snp_addr[OFF_W-1:0],
                                   repl_addr[OFF_W-1:0]};

    always_comb begin
        cmp_en[0]  = snp_valid && kind_takes_ownership(snp_kind);
        cmp_blk[0] = snp_addr[AW-1:OFF_W];
        cmp_en[1]  = repl_valid;
        cmp_blk[1] = repl_addr[AW-1:OFF_W];
    end

    generate
        for (genvar i = 0; i < NCMP; i++) begin : g_cmp
            llsc_blk_cmp #(.BW(BW)) u_cmp (
                .en    (cmp_en[i]),
                .blk_a (cmp_blk[i]),
                .blk_b (resv_blk),
                .hit   (cmp_hit[i])
            );
        end
    endgenerate

    always_comb begin
        kill.snoop = cmp_hit[0];
        kill.evict = cmp_hit[1];
        kill.ctx   = ctx_switch;
        kill_any   = |kill;
        sc_ok      = sc_req && armed && !kill_any;
    end

    llsc_resv_reg #(.BW(BW)) u_resv (
        .clk     (clk),
        .rst     (rst),
        .arm     (ll_req),
        .arm_blk (ll_addr[AW-1:OFF_W]),
        .drop    (kill_any || sc_req),
        .armed   (armed),
        .blk     (resv_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.done <= sc_req;
            res_q.pass <= sc_ok;
            res_q.wr   <= sc_ok;
        end
    end

    llsc_backoff #(.MAX_WIN(MAX_WIN), .ENABLE(EXCL_BACKOFF)) u_bo (
        .clk      (clk),
        .rst      (rst),
        .fail_evt (sc_req && !sc_ok),
        .pass_evt (sc_ok),
        .bus_ok   (bus_ok)
    );

    always_comb begin
        sc_done = res_q.done;
        sc_pass = res_q.pass;
        sc_wr   = res_q.wr;
    end
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
    parameter bit EXCL_BACKOFF = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic ll_req,
    input logic sc_req,
    input logic ctx_switch,
    input logic sc_done,
    input logic sc_pass,
    input logic sc_wr,
    input logic bus_ok
);
    assert_wr_needs_pass_R6: assert property (@(posedge clk) disable iff (rst)
        sc_wr |-> (sc_pass && sc_done));

    assert_result_next_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> sc_done);

    assert_no_spurious_done_R5: assert property (@(posedge clk) disable iff (rst)
        !sc_req |=> !sc_done);

    assert_ctx_fails_sc_R4: assert property (@(posedge clk) disable iff (rst)
        (sc_req && ctx_switch) |=> !sc_pass);

    assert_consumed_after_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (sc_done && sc_pass && sc_req && !ll_req) |=> !sc_pass);

    assert_reset_outputs_R11: assert property (@(posedge clk)
        $past(rst) |-> (!sc_done && !sc_wr && bus_ok));

    generate
        if (EXCL_BACKOFF) begin : g_bo
            assert_fail_closes_bus_R9: assert property (@(posedge clk) disable iff (rst)
                (sc_done && !sc_pass) |-> !bus_ok);
            assert_pass_opens_bus_R10: assert property (@(posedge clk) disable iff (rst)
                (sc_done && sc_pass) |-> bus_ok);
        end
    endgenerate
endmodule

bind llsc_resv_unit llsc_resv_chk #(.EXCL_BACKOFF(EXCL_BACKOFF)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ll_req     (ll_req),
    .sc_req     (sc_req),
    .ctx_switch (ctx_switch),
    .sc_done    (sc_done),
    .sc_pass    (sc_pass),
    .sc_wr      (sc_wr),
    .bus_ok     (bus_ok)
);

// File: tb/sim_llsc_resv_unit.sv
`timescale 1ns/1ps
module sim_llsc_resv_unit;
    localparam int AW = 16;
    localparam int BLK = 16;
    localparam int MAXW = 8;

    logic clk = 1'b0;
    logic rst;
    logic ll_req, sc_req, snp_valid, repl_valid, ctx_switch;
    logic [AW-1:0] ll_addr, snp_addr, repl_addr;
    logic [1:0] snp_kind;
    logic sc_done, sc_pass, sc_wr, bus_ok;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    llsc_resv_unit #(.AW(AW), .BLK_BYTES(BLK), .MAX_WIN(MAXW), .EXCL_BACKOFF(1'b1)) u0 (
        .clk(clk), .rst(rst), .ll_req(ll_req), .ll_addr(ll_addr), .sc_req(sc_req),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
        .repl_valid(repl_valid), .repl_addr(repl_addr), .ctx_switch(ctx_switch),
        .sc_done(sc_done), .sc_pass(sc_pass), .sc_wr(sc_wr), .bus_ok(bus_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ll_req = 0; sc_req = 0; snp_valid = 0; repl_valid = 0; ctx_switch = 0;
        snp_kind = 2'b00;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic do_ll(input logic [AW-1:0] a);
        ll_req = 1; ll_addr = a;
        tick();
    endtask

    // SC in this cycle with whatever else was set; checks pass and write enable.
    task automatic do_sc_chk(input bit exp_pass, input string req);
        sc_req = 1;
        @(negedge clk);
        idle();
        chk(sc_done === 1'b1, req, int'(sc_done), 1);
        chk(sc_pass === exp_pass && sc_wr === exp_pass, req,
            int'({sc_pass, sc_wr}), exp_pass ? 3 : 0);
    endtask

    task automatic wait_bus();
        while (bus_ok !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        int w;
        int low;
        idle();
        ll_addr = '0; snp_addr = '0; repl_addr = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R11 reset state
        chk(sc_done === 0 && sc_pass === 0 && sc_wr === 0, "R11", int'({sc_done, sc_pass, sc_wr}), 0);
        chk(bus_ok === 1, "R11 bus_ok", int'(bus_ok), 1);
        do_sc_chk(1'b0, "R11 no reservation");
        wait_bus();

        base = 16'h1230;
        // R1 basic LL then SC, across offsets of the LL
        for (int off = 0; off < BLK; off += 5) begin
            do_ll(base + AW'(off));
            do_sc_chk(1'b1, "R1");
        end

        // R2 snoop sweep: block delta x offset x kind
        for (int d = 0; d < 2; d++)
            for (int off = 0; off < BLK; off++)
                for (int k = 0; k < 4; k++) begin
                    do_ll(base + 16'd5);
                    snp_valid = 1; snp_kind = 2'(k);
                    snp_addr = base + AW'(d * BLK + off);
                    tick();
                    do_sc_chk(!(d == 0 && (k == 1 || k == 2)), "R2");
                end

        // R3 eviction sweep
        for (int d = -1; d < 2; d++)
            for (int off = 0; off < BLK; off++) begin
                do_ll(base + 16'd9);
                repl_valid = 1; repl_addr = AW'(int'(base) + d * BLK + off);
                tick();
                do_sc_chk(d != 0, "R3");
            end

        // R4 context switch with unrelated address state
        do_ll(base);
        ctx_switch = 1; tick();
        do_sc_chk(1'b0, "R4");

        // R7 consume on pass
        do_ll(base);
        do_sc_chk(1'b1, "R7 first");
        do_sc_chk(1'b0, "R7 second");

        // R8 same-cycle cases
        do_ll(base);
        snp_valid = 1; snp_kind = 2'b01; snp_addr = base + 16'd3;
        do_sc_chk(1'b0, "R8 sc+inval");
        do_ll(base);
        snp_valid = 1; snp_kind = 2'b10; snp_addr = base + 16'd16;
        do_sc_chk(1'b1, "R8 sc+other-block rdx");
        do_ll(base);
        repl_valid = 1; repl_addr = base;
        do_sc_chk(1'b0, "R8 sc+evict");
        do_ll(base);
        ctx_switch = 1;
        do_sc_chk(1'b0, "R8 sc+ctx");
        ll_req = 1; ll_addr = base; snp_valid = 1; snp_kind = 2'b01; snp_addr = base;
        tick();
        do_sc_chk(1'b1, "R8 ll+inval");
        ll_req = 1; ll_addr = base;
        do_sc_chk(1'b0, "R8 ll+sc old");
        do_sc_chk(1'b1, "R8 ll+sc new");

        // R9 backoff doubling and saturation
        wait_bus();
        do_ll(base);
        do_sc_chk(1'b1, "R10 pass");
        chk(bus_ok === 1, "R10 bus_ok on pass", int'(bus_ok), 1);
        w = 1;
        for (int n = 0; n < 6; n++) begin
            sc_req = 1;
            @(negedge clk);
            idle();
            low = 0;
            while (bus_ok === 0 && low < 100) begin
                low++;
                @(negedge clk);
            end
            chk(low == w, "R9 window", low, w);
            w = (w * 2 > MAXW) ? MAXW : w * 2;
        end
        // R10 pass resets window to 1
        do_ll(base);
        do_sc_chk(1'b1, "R10 reset");
        sc_req = 1;
        @(negedge clk);
        idle();
        low = 0;
        while (bus_ok === 0 && low < 100) begin
            low++;
            @(negedge clk);
        end
        chk(low == 1, "R10 window after pass", low, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule